// File: doc/BRIEF.md
# Scaled FP8 to BFloat16 Vector Widener

This block widens eight 8-bit floating-point elements into eight BFloat16 values. While it widens them, it multiplies each value by a power-of-two downscale factor. The source is a 128-bit vector. One control bit picks which 64-bit half of the source supplies the eight bytes. A second control bit picks one of two operation sets. Each set has its own 6-bit scale amount and its own one-bit encoding select.

Each byte is read either as a 5-bit-exponent/2-bit-mantissa code or as a 4-bit-exponent/3-bit-mantissa code. The result goes to the matching 16-bit lane of a 128-bit output. BFloat16 has an 8-bit exponent, so every finite input stays exactly representable after scaling, even at the largest downscale. For that reason the datapath needs no rounding.

The block fits into a vector execution pipeline as a single stage. With the default parameters the result is registered, one cycle after the operands.

Top module: `fp8_bf16_widen`

## Requirements
- R1: Byte e of the selected half produces the 16-bit result placed at dst[16e+15:16e], for e = 0..7.
- R2: hi_half = 0 takes src[63:0]; hi_half = 1 takes src[127:64]. The other half has no effect on dst.
- R3: use_set2 = 0 uses scale_a and fmt_a; use_set2 = 1 uses scale_b and fmt_b. The unused scale and format have no effect on dst.
- R4: Every finite nonzero result equals the input value times 2^-k, where k is the selected 6-bit scale (0..63). It is encoded as an exact BFloat16 normal: sign at bit 15, biased exponent (bias 127) at [14:7], fraction at [6:0].
- R5: With format select 0, a byte is sign[7], exponent[6:2] with bias 15, mantissa[1:0]. Exponent 31 holds the infinities (mantissa 0) and the NaNs (mantissa nonzero).
- R6: With format select 1, a byte is sign[7], exponent[6:3] with bias 7, mantissa[2:0]. There are no infinities, and only magnitude 7'h7F is NaN.
- R7: Subnormal inputs (exponent field 0, mantissa nonzero) are normalized, so their value is mantissa × 2^(1-bias-MW) and the result is still exact.
- R8: An input zero of either sign yields a BFloat16 zero with the same sign (16'h0000 or 16'h8000), whatever the scale.
- R9: A format-0 infinity yields 16'h7F80 or 16'hFF80 with its sign, and the scale does not apply to it.
- R10: Every NaN input yields 16'h7FC0.
- R11: The result appears on dst one clock after the operands. A synchronous active-high rst clears dst to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src | input | 128 | Source vector |
| hi_half | input | 1 | Half select: 0 = low 64 bits, 1 = high 64 bits |
| use_set2 | input | 1 | Operation set select: 0 = set A, 1 = set B |
| scale_a | input | 6 | Downscale exponent for set A |
| scale_b | input | 6 | Downscale exponent for set B |
| fmt_a | input | 1 | Encoding select for set A (0 = 5-bit exponent, 1 = 4-bit exponent) |
| fmt_b | input | 1 | Encoding select for set B |
| dst | output | 128 | Eight packed BFloat16 results |

## Verification
Operand selection (half and set) and special-value mapping act in the same cycle. Every vector therefore carries data in the unused half that differs from the selected half, and the unused set is given the opposite encoding and a different scale. A wrong selection then shows up as a value error in some lane. All 256 codes in both encodings are swept at several scales, from 0 up to the extreme 63, and under all four half/set combinations. Every lane is compared on every clock against a real-number model of the requirements. A reset pulse applied in the middle of the traffic checks that clearing the output wins over a result that is in flight.

// File: rtl/fp8cvt_pkg.sv
package fp8cvt_pkg;

  localparam int BF_W     = 16;
  localparam int BF_FRAC  = 7;
  localparam int BF_BIAS  = 127;
  localparam int FP8_W    = 8;
  localparam logic [15:0] BF_QNAN = 16'h7FC0;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_FIN  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } fp_cls_e;

  // decoded element: class, sign, unbiased exponent, left-aligned fraction
  typedef struct packed {
    fp_cls_e             cls;
    logic                sign;
    logic signed [7:0]   uexp;
    logic [BF_FRAC-1:0]  frac;
  } fp_dec_t;

endpackage

// File: rtl/fp8_decode.sv
module fp8_decode
  import fp8cvt_pkg::*;
#(
  parameter int EW      = 5,
  parameter int MW      = 2,
  parameter int BIAS    = 15,
  parameter bit HAS_INF = 1'b1
) (
  input  logic [FP8_W-1:0] code,
  output fp_dec_t          dec
);

  localparam int SHW = BF_FRAC + MW + 1;

  logic [EW-1:0]  expf;
  logic [MW-1:0]  mant;
  logic [SHW-1:0] shifted;
  int             lead;

  assign expf = code[MW +: EW];
  assign mant = code[0 +: MW];

  always_comb begin
    lead    = 0;
    for (int i = 0; i < MW; i++) begin
      if (mant[i]) lead = i;
    end
    shifted = SHW'(mant) << (BF_FRAC - lead);

    dec      = '0;
    dec.sign = code[FP8_W-1];
    dec.cls  = CLS_FIN;
    dec.uexp = 8'(int'(expf) - BIAS);
    dec.frac = {mant, {(BF_FRAC-MW){1'b0}}};

    if (expf == '0) begin
      if (mant == '0) begin
        dec.cls = CLS_ZERO;
      end else begin
        // subnormal: move the leading one to the hidden position
        dec.uexp = 8'(1 - BIAS - (MW - lead));
        dec.frac = shifted[BF_FRAC-1:0];
      end
    end else if (expf == '1) begin
      if (HAS_INF) begin
        dec.cls = (mant == '0) ? CLS_INF : CLS_NAN;
      end else if (mant == '1) begin
        dec.cls = CLS_NAN;
      end
    end
  end

endmodule

// File: rtl/fp8_lane.sv
module fp8_lane
  import fp8cvt_pkg::*;
#(
  parameter int SCALE_W = 6
) (
  input  logic [FP8_W-1:0]   code,
  input  logic               fmt,
  input  logic [SCALE_W-1:0] k,
  output logic [BF_W-1:0]    bf
);

  fp_dec_t dec_w [2];
  fp_dec_t dec;
  int      bexp;

  // one decoder per supported encoding; the select picks one
  for (genvar g = 0; g < 2; g++) begin : g_dec
    fp8_decode #(
      .EW      (g == 0 ? 5 : 4),
      .MW      (g == 0 ? 2 : 3),
      .BIAS    (g == 0 ? 15 : 7),
      .HAS_INF (g == 0)
    ) u_dec (
      .code (code),
      .dec  (dec_w[g])
    );
  end

  assign dec = fmt ? dec_w[1] : dec_w[0];

  always_comb begin
    bexp = int'(dec.uexp) + BF_BIAS - int'(k);
    unique case (dec.cls)
      CLS_ZERO: bf = {dec.sign, 15'h0000};
      CLS_INF:  bf = {dec.sign, 8'hFF, 7'h00};
      CLS_NAN:  bf = BF_QNAN;
      default:  bf = {dec.sign, 8'(bexp), dec.frac};
    endcase
  end

endmodule

// File: rtl/fp8_bf16_widen.sv
module fp8_bf16_widen
  import fp8cvt_pkg::*;
#(
  parameter int LANES   = 8,
  parameter int SCALE_W = 6,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2*LANES*8-1:0]     src,
  input  logic                     hi_half,
  input  logic                     use_set2,
  input  logic [SCALE_W-1:0]       scale_a,
  input  logic [SCALE_W-1:0]       scale_b,
  input  logic                     fmt_a,
  input  logic                     fmt_b,
  output logic [LANES*16-1:0]      dst
);

  localparam int HALF_W = LANES * FP8_W;
  localparam int VEC_W  = 2 * HALF_W;
  localparam int DST_W  = LANES * BF_W;

  logic [HALF_W-1:0]  half_sel;
  logic [SCALE_W-1:0] k_sel;
  logic               fmt_sel;
  logic [DST_W-1:0]   conv;

  assign half_sel = hi_half  ? src[VEC_W-1:HALF_W] : src[HALF_W-1:0];
  assign k_sel    = use_set2 ? scale_b : scale_a;
  assign fmt_sel  = use_set2 ? fmt_b   : fmt_a;

  for (genvar e = 0; e < LANES; e++) begin : g_lane
    fp8_lane #(.SCALE_W(SCALE_W)) u_lane (
      .code (half_sel[e*FP8_W +: FP8_W]),
      .fmt  (fmt_sel),
      .k    (k_sel),
      .bf   (conv[e*BF_W +: BF_W])
    );
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) dst <= '0;
      else     dst <= conv;
    end
  end else begin : g_comb
    logic unused_ck;
    assign unused_ck = clk ^ rst;
    assign dst = conv;
  end

endmodule

// File: rtl/fp8_bf16_widen_chk.sv
module fp8_bf16_widen_chk #(
  parameter int LANES   = 8,
  parameter int SCALE_W = 6,
  parameter bit REG_OUT = 1'b1
) (
  input logic                 clk,
  input logic                 rst,
  input logic [2*LANES*8-1:0] src,
  input logic                 hi_half,
  input logic                 use_set2,
  input logic [SCALE_W-1:0]   scale_a,
  input logic [SCALE_W-1:0]   scale_b,
  input logic                 fmt_a,
  input logic                 fmt_b,
  input logic [LANES*16-1:0]  dst
);

  localparam int HALF_W = LANES * 8;

  logic [7:0] b0;
  logic       f0, z0, n0, i0;
  logic       unused_sc;

  assign b0 = hi_half ? src[HALF_W +: 8] : src[7:0];
  assign f0 = use_set2 ? fmt_b : fmt_a;
  assign z0 = (b0[6:0] == 7'h00);
  assign n0 = f0 ? (b0[6:0] == 7'h7F) : (b0[6:2] == 5'h1F && b0[1:0] != 2'b00);
  assign i0 = !f0 && (b0[6:0] == 7'h7C);
  assign unused_sc = ^{scale_a, scale_b};

  if (REG_OUT) begin : g_chk
    p_rst_clear_r11: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> dst == '0);

    p_zero_sign_r8: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(z0)) |-> dst[15:0] == {$past(b0[7]), 15'h0000});

    p_nan_default_r10: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(n0)) |-> dst[15:0] == 16'h7FC0);

    p_inf_keep_r9: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(i0)) |-> dst[15:0] == {$past(b0[7]), 15'h7F80});

    p_sign_follow_r4: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(n0)) |-> dst[15] == $past(b0[7]));
  end

endmodule

bind fp8_bf16_widen fp8_bf16_widen_chk #(
  .LANES   (LANES),
  .SCALE_W (SCALE_W),
  .REG_OUT (REG_OUT)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .src      (src),
  .hi_half  (hi_half),
  .use_set2 (use_set2),
  .scale_a  (scale_a),
  .scale_b  (scale_b),
  .fmt_a    (fmt_a),
  .fmt_b    (fmt_b),
  .dst      (dst)
);

// File: tb/sim_fp8_bf16_widen.sv
`timescale 1ns/1ps
module sim_fp8_bf16_widen;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] src = '0;
  logic         hi_half = 1'b0, use_set2 = 1'b0;
  logic [5:0]   scale_a = '0, scale_b = '0;
  logic         fmt_a = 1'b0, fmt_b = 1'b0;
  logic [127:0] dst;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  fp8_bf16_widen u0 (
    .clk(clk), .rst(rst), .src(src), .hi_half(hi_half), .use_set2(use_set2),
    .scale_a(scale_a), .scale_b(scale_b), .fmt_a(fmt_a), .fmt_b(fmt_b), .dst(dst)
  );

  function automatic real pow2(input int n);
    real r = 1.0;
    if (n >= 0) for (int i = 0; i < n; i++) r = r * 2.0;
    else        for (int i = 0; i < -n; i++) r = r / 2.0;
    return r;
  endfunction

  // reference built from the requirement text (R4..R10)
  function automatic logic [15:0] ref_bf(input logic [7:0] c, input bit fmt, input int k);
    logic sg = c[7];
    int   e, m, ex, fr;
    real  mag;
    if (!fmt) begin
      e = int'(c[6:2]); m = int'(c[1:0]);
      if (e == 31) return (m == 0) ? {sg, 15'h7F80} : 16'h7FC0;
      mag = (e == 0) ? (m / 4.0) * pow2(-14) : (1.0 + m / 4.0) * pow2(e - 15);
    end else begin
      e = int'(c[6:3]); m = int'(c[2:0]);
      if (c[6:0] == 7'h7F) return 16'h7FC0;
      mag = (e == 0) ? (m / 8.0) * pow2(-6) : (1.0 + m / 8.0) * pow2(e - 7);
    end
    if (mag == 0.0) return {sg, 15'h0000};
    mag = mag * pow2(-k);
    ex = 0;
    while (mag >= 2.0) begin mag = mag / 2.0; ex++; end
    while (mag < 1.0)  begin mag = mag * 2.0; ex--; end
    fr = int'((mag - 1.0) * 128.0);
    return {sg, 8'(ex + 127), 7'(fr)};
  endfunction

  function automatic string tag_of(input logic [7:0] c, input bit fmt);
    if (!fmt) begin
      if (c[6:2] == 5'h1F) return (c[1:0] == 0) ? "R9" : "R10";
      if (c[6:0] == 0) return "R8";
      if (c[6:2] == 0) return "R7";
      return "R5";
    end
    if (c[6:0] == 7'h7F) return "R10";
    if (c[6:0] == 0) return "R8";
    if (c[6:3] == 0) return "R7";
    return "R6";
  endfunction

  // one vector: selected data, opposite half/set hold decoys (R2 R3)
  task automatic run_vec(input logic [63:0] dat, input bit hi, input bit s2,
                         input bit fsel, input int k);
    logic [127:0] expv;
    @(negedge clk);
    src      = hi ? {dat, ~dat ^ 64'hA5A5_3C3C_0F0F_9696} : {~dat ^ 64'h5A5A_C3C3_F0F0_6969, dat};
    hi_half  = hi;
    use_set2 = s2;
    fmt_a    = s2 ? ~fsel : fsel;
    fmt_b    = s2 ? fsel : ~fsel;
    scale_a  = s2 ? 6'((k + 23) % 64) : 6'(k);
    scale_b  = s2 ? 6'(k) : 6'((k + 37) % 64);
    for (int e = 0; e < 8; e++) expv[16*e +: 16] = ref_bf(dat[8*e +: 8], fsel, k);
    @(posedge clk);  // R11: one register stage
    #1;
    for (int e = 0; e < 8; e++) begin
      n_cmp++;
      if (dst[16*e +: 16] !== expv[16*e +: 16]) begin
        n_bad++;
        $display("FAIL %s (R1 R2 R3 R4) code=%02h fmt=%0d k=%0d hi=%0d set2=%0d lane%0d: got %04h exp %04h",
                 tag_of(dat[8*e +: 8], fsel), dat[8*e +: 8], fsel, k, hi, s2, e,
                 dst[16*e +: 16], expv[16*e +: 16]);
      end
    end
  endtask

  task automatic chk_zero(input string what);
    n_cmp++;
    if (dst !== '0) begin
      n_bad++;
      $display("FAIL R11 %s: got %032h exp 0", what, dst);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int ks[4] = '{0, 1, 17, 63};
    logic [63:0] d;
    repeat (3) @(posedge clk);
    #1 chk_zero("reset state");  // R11
    @(negedge clk) rst = 1'b0;

    // full sweep: all codes, both encodings, four scales, all half/set pairs
    for (int f = 0; f < 2; f++)
      for (int ki = 0; ki < 4; ki++)
        for (int hs = 0; hs < 4; hs++)
          for (int v = 0; v < 32; v++) begin
            for (int e = 0; e < 8; e++) d[8*e +: 8] = 8'(v * 8 + e);
            run_vec(d, hs[0], hs[1], f[0], ks[ki]);
          end

    // R11: reset pulse in the middle of traffic clears the output
    @(negedge clk) src = {128{1'b1}}; rst = 1'b1;
    @(posedge clk); #1 chk_zero("mid-run reset");
    @(negedge clk) rst = 1'b0;
    run_vec(64'h7C_FC_7F_FF_00_80_01_81, 1'b1, 1'b0, 1'b0, 63);  // R9 R10 R8 R7
    run_vec(64'h7E_FE_7F_FF_00_80_01_08, 1'b0, 1'b1, 1'b1, 63);  // R6 R10 R7

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule